// File: doc/BRIEF.md
# Serial Port Register Address Decoder

This block sits between a 16-bit I/O bus and the register file of one eight-byte serial port window. It works out whether a bus access belongs to the port and, if it does, which of the port's registers the access targets. The port's window base comes from an 8-bit bank of active-low setting switches that cover address bits 10 to 3. Bits 15 to 11 must be zero, and a separate enable input can take the whole port off the bus.

For an access that hits, the low three address bits, the direction and a divisor-access flag choose one of twelve register targets. The block raises a single one-hot read or write strobe in the same cycle as the access. It also returns read data to the bus. The writable registers are kept here as plain byte storage. The divisor-access flag is bit 7 of the stored line-control byte. The read-only sources (receive buffer, interrupt identity, line status and modem status) come in as inputs from the rest of the port.

Top module: `sio_reg_decode`

## Requirements
- R1: The port hits only when addr[15:11] is zero and addr[10:3] equals the bitwise inverse of base_sw_i. A switch bit of 1 demands an address bit of 0. Switch value 8'h80 places the window at 0x3F8 and 8'hA0 places it at 0x2F8.
- R2: While port_en_i is low, sel_o is 0, bus_rdata_o is 0 and no strobe is raised, whatever the address.
- R3: When an access misses, sel_o is 0, bus_rdata_o is 0 and no strobe is raised.
- R4: With the divisor-access flag clear, a read at offset 0 returns rxbuf_i and a write at offset 0 stores txhold_o. A read or write at offset 1 accesses the interrupt-enable byte inten_o.
- R5: A read at offset 2 returns intid_i. A write at offset 2 stores fifoctl_o.
- R6: With the divisor-access flag set, offsets 0 and 1 read and write the low and high divisor bytes, seen as divisor_o = {high, low}. txhold_o and inten_o are left untouched, and rxbuf_i is not selected.
- R7: The divisor-access flag is linectl_o[7]. Offset 3 reads and writes linectl_o. A change applies from the access in the cycle right after the write.
- R8: Offset 4 reads and writes modemctl_o. Offset 7 reads and writes a scratch byte. Offsets 5 and 6 read linestat_i and modemstat_i. Writes to offsets 5 and 6 raise no strobe and change no stored byte, although sel_o stays high.
- R9: The strobes are valid only in the cycle of the access, and at most one bit of {wr_stb_o, rd_stb_o} is high. Bit order for both vectors: 0 rx buffer, 1 tx holding, 2 interrupt enable, 3 interrupt identity, 4 FIFO control, 5 line control, 6 modem control, 7 line status, 8 modem status, 9 scratch, 10 divisor low, 11 divisor high.
- R10: An access with bus_rd_i and bus_wr_i both high is void. sel_o is 0, bus_rdata_o is 0, no strobe is raised and nothing is stored.
- R11: After reset every stored byte is zero, including the divisor-access flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 16 | I/O address |
| bus_rd_i | input | 1 | Read access this cycle |
| bus_wr_i | input | 1 | Write access this cycle |
| bus_wdata_i | input | 8 | Write data |
| base_sw_i | input | 8 | Active-low base switches for addr[10:3] |
| port_en_i | input | 1 | Port enable |
| rxbuf_i | input | 8 | Receive buffer value |
| intid_i | input | 8 | Interrupt identity value |
| linestat_i | input | 8 | Line status value |
| modemstat_i | input | 8 | Modem status value |
| sel_o | output | 1 | Port selected by a valid access |
| bus_rdata_o | output | 8 | Read data, zero unless a read hits |
| rd_stb_o | output | 12 | One-hot read strobes |
| wr_stb_o | output | 12 | One-hot write strobes |
| txhold_o | output | 8 | Stored transmit holding byte |
| inten_o | output | 8 | Stored interrupt enable byte |
| fifoctl_o | output | 8 | Stored FIFO control byte |
| linectl_o | output | 8 | Stored line control byte |
| modemctl_o | output | 8 | Stored modem control byte |
| divisor_o | output | 16 | Stored divisor {high, low} |

## Verification
Two functions can meet in one clock edge. The first is the write to the line-control byte that flips the divisor-access flag. The second is the steering of the access that follows it. The bench issues the flag write and then, with no idle cycle between, an access at offset 0. It judges the result by which strobe fires and by whether divisor_o or txhold_o took the data. It also drives read and write together in one cycle and checks that the access is voided rather than half-performed.

// File: rtl/sio_dec_pkg.sv
package sio_dec_pkg;
  localparam int unsigned NREG = 12;

  typedef enum logic [3:0] {
    RG_RXBUF     = 4'd0,
    RG_TXHOLD    = 4'd1,
    RG_INTEN     = 4'd2,
    RG_INTID     = 4'd3,
    RG_FIFOCTL   = 4'd4,
    RG_LINECTL   = 4'd5,
    RG_MODEMCTL  = 4'd6,
    RG_LINESTAT  = 4'd7,
    RG_MODEMSTAT = 4'd8,
    RG_SCRATCH   = 4'd9,
    RG_DIVLO     = 4'd10,
    RG_DIVHI     = 4'd11
  } reg_e;

  localparam int unsigned DIV_ACCESS_BIT = 7;
endpackage

// File: rtl/sio_addr_match.sv
module sio_addr_match #(
  parameter int unsigned AW     = 16,
  parameter int unsigned OFF_W  = 3,
  parameter int unsigned BASE_W = 8
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [BASE_W-1:0] base_sw_i,
  input  logic              port_en_i,
  output logic              hit_o
);
  localparam int unsigned TOP_LO = OFF_W + BASE_W;

  logic upper_zero;
  logic base_eq;

  assign upper_zero = (addr_i[AW-1:TOP_LO] == '0);
  // switches are active-low: on (1) demands address bit 0
  assign base_eq    = (addr_i[TOP_LO-1:OFF_W] == ~base_sw_i);
  assign hit_o      = port_en_i & upper_zero & base_eq;
endmodule

// File: rtl/sio_reg_steer.sv
module sio_reg_steer
  import sio_dec_pkg::*;
#(
  parameter int unsigned OFF_W = 3
) (
  input  logic             hit_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             div_access_i,
  output logic             sel_o,
  output logic [NREG-1:0]  rd_stb_o,
  output logic [NREG-1:0]  wr_stb_o
);
  logic rd_ok, wr_ok;

  assign sel_o = hit_i & (rd_i ^ wr_i);
  assign rd_ok = sel_o & rd_i;
  assign wr_ok = sel_o & wr_i;

  always_comb begin
    rd_stb_o = '0;
    wr_stb_o = '0;
    unique case (off_i)
      3'd0: begin
        if (div_access_i) begin
          rd_stb_o[RG_DIVLO] = rd_ok;
          wr_stb_o[RG_DIVLO] = wr_ok;
        end else begin
          rd_stb_o[RG_RXBUF]  = rd_ok;
          wr_stb_o[RG_TXHOLD] = wr_ok;
        end
      end
      3'd1: begin
        if (div_access_i) begin
          rd_stb_o[RG_DIVHI] = rd_ok;
          wr_stb_o[RG_DIVHI] = wr_ok;
        end else begin
          rd_stb_o[RG_INTEN] = rd_ok;
          wr_stb_o[RG_INTEN] = wr_ok;
        end
      end
      3'd2: begin
        rd_stb_o[RG_INTID]   = rd_ok;
        wr_stb_o[RG_FIFOCTL] = wr_ok;
      end
      3'd3: begin
        rd_stb_o[RG_LINECTL] = rd_ok;
        wr_stb_o[RG_LINECTL] = wr_ok;
      end
      3'd4: begin
        rd_stb_o[RG_MODEMCTL] = rd_ok;
        wr_stb_o[RG_MODEMCTL] = wr_ok;
      end
      3'd5: rd_stb_o[RG_LINESTAT]  = rd_ok;
      3'd6: rd_stb_o[RG_MODEMSTAT] = rd_ok;
      default: begin
        rd_stb_o[RG_SCRATCH] = rd_ok;
        wr_stb_o[RG_SCRATCH] = wr_ok;
      end
    endcase
  end
endmodule

// File: rtl/sio_reg_store.sv
module sio_reg_store
  import sio_dec_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] rd_stb_i,
  input  logic [NREG-1:0] wr_stb_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   rxbuf_i,
  input  logic [DW-1:0]   intid_i,
  input  logic [DW-1:0]   linestat_i,
  input  logic [DW-1:0]   modemstat_i,
  output logic [DW-1:0]   rdata_o,
  output logic [DW-1:0]   txhold_o,
  output logic [DW-1:0]   inten_o,
  output logic [DW-1:0]   fifoctl_o,
  output logic [DW-1:0]   linectl_o,
  output logic [DW-1:0]   modemctl_o,
  output logic [2*DW-1:0] divisor_o,
  output logic            div_access_o
);
  logic [DW-1:0] store_q [NREG];
  logic [DW-1:0] rd_src  [NREG];

  // only writable targets get a flop; the rest tie to zero
  for (genvar k = 0; k < NREG; k++) begin : g_store
    if (k == RG_RXBUF || k == RG_INTID || k == RG_LINESTAT || k == RG_MODEMSTAT) begin : g_ro
      assign store_q[k] = '0;
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= '0;
        else if (wr_stb_i[k]) q <= wdata_i;
      end
      assign store_q[k] = q;
    end
  end

  always_comb begin
    for (int k = 0; k < NREG; k++) rd_src[k] = store_q[k];
    rd_src[RG_RXBUF]     = rxbuf_i;
    rd_src[RG_INTID]     = intid_i;
    rd_src[RG_LINESTAT]  = linestat_i;
    rd_src[RG_MODEMSTAT] = modemstat_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NREG; k++)
      if (rd_stb_i[k]) rdata_o = rdata_o | rd_src[k];
  end

  assign txhold_o     = store_q[RG_TXHOLD];
  assign inten_o      = store_q[RG_INTEN];
  assign fifoctl_o    = store_q[RG_FIFOCTL];
  assign linectl_o    = store_q[RG_LINECTL];
  assign modemctl_o   = store_q[RG_MODEMCTL];
  assign divisor_o    = {store_q[RG_DIVHI], store_q[RG_DIVLO]};
  assign div_access_o = store_q[RG_LINECTL][DIV_ACCESS_BIT];
endmodule

// File: rtl/sio_reg_decode.sv
module sio_reg_decode
  import sio_dec_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned OFF_W  = 3,
  parameter int unsigned BASE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  input  logic [BASE_W-1:0] base_sw_i,
  input  logic              port_en_i,
  input  logic [DW-1:0]     rxbuf_i,
  input  logic [DW-1:0]     intid_i,
  input  logic [DW-1:0]     linestat_i,
  input  logic [DW-1:0]     modemstat_i,
  output logic              sel_o,
  output logic [DW-1:0]     bus_rdata_o,
  output logic [NREG-1:0]   rd_stb_o,
  output logic [NREG-1:0]   wr_stb_o,
  output logic [DW-1:0]     txhold_o,
  output logic [DW-1:0]     inten_o,
  output logic [DW-1:0]     fifoctl_o,
  output logic [DW-1:0]     linectl_o,
  output logic [DW-1:0]     modemctl_o,
  output logic [2*DW-1:0]   divisor_o
);
  logic hit;
  logic div_access;

  sio_addr_match #(.AW(AW), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_match (
    .addr_i    (bus_addr_i),
    .base_sw_i (base_sw_i),
    .port_en_i (port_en_i),
    .hit_o     (hit)
  );

  sio_reg_steer #(.OFF_W(OFF_W)) u_steer (
    .hit_i        (hit),
    .rd_i         (bus_rd_i),
    .wr_i         (bus_wr_i),
    .off_i        (bus_addr_i[OFF_W-1:0]),
    .div_access_i (div_access),
    .sel_o        (sel_o),
    .rd_stb_o     (rd_stb_o),
    .wr_stb_o     (wr_stb_o)
  );

  sio_reg_store #(.DW(DW)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_stb_i     (rd_stb_o),
    .wr_stb_i     (wr_stb_o),
    .wdata_i      (bus_wdata_i),
    .rxbuf_i      (rxbuf_i),
    .intid_i      (intid_i),
    .linestat_i   (linestat_i),
    .modemstat_i  (modemstat_i),
    .rdata_o      (bus_rdata_o),
    .txhold_o     (txhold_o),
    .inten_o      (inten_o),
    .fifoctl_o    (fifoctl_o),
    .linectl_o    (linectl_o),
    .modemctl_o   (modemctl_o),
    .divisor_o    (divisor_o),
    .div_access_o (div_access)
  );
endmodule

// File: rtl/sio_reg_decode_chk.sv
module sio_reg_decode_chk
  import sio_dec_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned BASE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     bus_addr_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic [BASE_W-1:0] base_sw_i,
  input logic              port_en_i,
  input logic              sel_o,
  input logic [DW-1:0]     bus_rdata_o,
  input logic [NREG-1:0]   rd_stb_o,
  input logic [NREG-1:0]   wr_stb_o,
  input logic [DW-1:0]     txhold_o,
  input logic [DW-1:0]     inten_o,
  input logic [DW-1:0]     linectl_o,
  input logic [2*DW-1:0]   divisor_o
);
  a_r9_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_stb_o, rd_stb_o}));

  a_r9_strobe_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_i && !bus_wr_i) |-> (rd_stb_o == '0 && wr_stb_o == '0));

  a_r2_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |-> (!sel_o && rd_stb_o == '0 && wr_stb_o == '0 && bus_rdata_o == '0));

  a_r3_unselected_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> (bus_rdata_o == '0 && rd_stb_o == '0 && wr_stb_o == '0));

  a_r10_collision_void: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_wr_i) |-> (!sel_o && wr_stb_o == '0 && rd_stb_o == '0));

  a_r7_linectl_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o[RG_LINECTL] |=> (linectl_o == $past(bus_wdata_i)));

  a_r6_divisor_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    linectl_o[DIV_ACCESS_BIT] |-> (!rd_stb_o[RG_RXBUF] && !wr_stb_o[RG_TXHOLD] &&
                                   !rd_stb_o[RG_INTEN] && !wr_stb_o[RG_INTEN]));

  a_r6_divisor_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_stb_o[RG_DIVLO] && !wr_stb_o[RG_DIVHI]) |=> $stable(divisor_o));

  a_r4_txhold_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o[RG_TXHOLD] |=> (txhold_o == $past(bus_wdata_i)));

  a_r4_inten_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_o[RG_INTEN] |=> $stable(inten_o));
endmodule

bind sio_reg_decode sio_reg_decode_chk #(.AW(AW), .DW(DW), .BASE_W(BASE_W)) u_chk (.*);

// File: tb/sim_sio_reg_decode.sv
`timescale 1ns/1ps
module sim_sio_reg_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  base_sw = 8'h80;
  logic        en = 1'b1;
  logic [7:0]  rxbuf = 8'hC3, intid = 8'hC1, lstat = 8'h60, mstat = 8'hB0;
  logic        sel;
  logic [7:0]  rdata, txh, ien, fctl, lctl, mctl;
  logic [11:0] rstb, wstb;
  logic [15:0] div;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  sio_reg_decode u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .base_sw_i(base_sw), .port_en_i(en),
    .rxbuf_i(rxbuf), .intid_i(intid), .linestat_i(lstat), .modemstat_i(mstat),
    .sel_o(sel), .bus_rdata_o(rdata), .rd_stb_o(rstb), .wr_stb_o(wstb),
    .txhold_o(txh), .inten_o(ien), .fifoctl_o(fctl), .linectl_o(lctl),
    .modemctl_o(mctl), .divisor_o(div)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // drives one access at a falling edge, samples the combinational outputs 2 ns later
  task automatic access(input logic r, input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    #2;
  endtask

  task automatic t_reset();
    check("R11 sel", sel, 0);
    check("R11 rdata", rdata, 0);
    check("R11 linectl", lctl, 0);
    check("R11 divisor", div, 0);
    check("R11 txhold", txh, 0);
    check("R11 modemctl", mctl, 0);
  endtask

  task automatic t_scratch_3f8();
    base_sw = 8'h80;
    access(0, 1, 16'h03FF, 8'h5A);
    check("R1 sel 3F8 window", sel, 1);
    check("R8 scratch wstb", wstb, 12'h200);
    idle();
    access(1, 0, 16'h03FF, 8'h00);
    check("R8 scratch readback", rdata, 8'h5A);
    check("R9 scratch rstb", rstb, 12'h200);
    idle();
  endtask

  task automatic t_miss();
    access(1, 0, 16'h0BFF, 8'h00);
    check("R1 upper bit set miss sel", sel, 0);
    check("R3 miss rdata", rdata, 0);
    check("R3 miss rstb", rstb, 0);
    access(0, 1, 16'h02FF, 8'hEE);
    check("R3 wrong base sel", sel, 0);
    check("R3 wrong base wstb", wstb, 0);
    idle();
    access(1, 0, 16'h03FF, 8'h00);
    check("R3 scratch untouched by miss", rdata, 8'h5A);
    idle();
  endtask

  task automatic t_disable();
    en = 1'b0;
    access(1, 0, 16'h03F8, 8'h00);
    check("R2 disabled sel", sel, 0);
    check("R2 disabled rdata", rdata, 0);
    access(0, 1, 16'h03F8, 8'h77);
    check("R2 disabled wstb", wstb, 0);
    idle();
    check("R2 disabled txhold", txh, 0);
    en = 1'b1;
  endtask

  task automatic t_off01();
    access(1, 0, 16'h03F8, 8'h00);
    check("R4 rx read data", rdata, 8'hC3);
    check("R4 rx rstb", rstb, 12'h001);
    access(0, 1, 16'h03F8, 8'h11);
    check("R4 tx wstb", wstb, 12'h002);
    access(0, 1, 16'h03F9, 8'h05);
    check("R4 tx stored", txh, 8'h11);
    check("R4 inten wstb", wstb, 12'h004);
    idle();
    check("R4 inten stored", ien, 8'h05);
  endtask

  task automatic t_off2();
    access(1, 0, 16'h03FA, 8'h00);
    check("R5 intid read", rdata, 8'hC1);
    check("R5 intid rstb", rstb, 12'h008);
    access(0, 1, 16'h03FA, 8'hC7);
    check("R5 fifo wstb", wstb, 12'h010);
    idle();
    check("R5 fifo stored", fctl, 8'hC7);
  endtask

  // flag write followed at once by an offset-0 access
  task automatic t_divisor();
    access(0, 1, 16'h03FB, 8'h83);
    check("R7 linectl wstb", wstb, 12'h020);
    access(0, 1, 16'h03F8, 8'h0C);
    check("R7 next-cycle redirect wstb", wstb, 12'h400);
    check("R7 linectl stored", lctl, 8'h83);
    access(0, 1, 16'h03F9, 8'h12);
    check("R6 divhi wstb", wstb, 12'h800);
    access(1, 0, 16'h03F8, 8'h00);
    check("R6 divisor value", div, 16'h120C);
    check("R6 divlo readback", rdata, 8'h0C);
    check("R6 divlo rstb", rstb, 12'h400);
    check("R6 txhold untouched", txh, 8'h11);
    check("R6 inten untouched", ien, 8'h05);
    access(0, 1, 16'h03FB, 8'h03);
    access(1, 0, 16'h03F9, 8'h00);
    check("R7 flag cleared inten read", rdata, 8'h05);
    check("R7 flag cleared inten rstb", rstb, 12'h004);
    idle();
  endtask

  task automatic t_upper_offsets();
    access(0, 1, 16'h03FC, 8'h0B);
    check("R8 modemctl wstb", wstb, 12'h040);
    access(0, 1, 16'h03FD, 8'hFF);
    check("R8 linestat write sel", sel, 1);
    check("R8 linestat write no wstb", wstb, 0);
    access(0, 1, 16'h03FE, 8'hFF);
    check("R8 modemstat write no wstb", wstb, 0);
    access(1, 0, 16'h03FD, 8'h00);
    check("R8 linestat read", rdata, 8'h60);
    check("R8 linestat rstb", rstb, 12'h080);
    access(1, 0, 16'h03FE, 8'h00);
    check("R8 modemstat read", rdata, 8'hB0);
    access(1, 0, 16'h03FF, 8'h00);
    check("R8 scratch intact after ro writes", rdata, 8'h5A);
    access(1, 0, 16'h03FC, 8'h00);
    check("R8 modemctl readback", rdata, 8'h0B);
    idle();
  endtask

  task automatic t_collision();
    access(1, 1, 16'h03FF, 8'hAA);
    check("R10 collide sel", sel, 0);
    check("R10 collide rdata", rdata, 0);
    check("R10 collide strobes", {wstb, rstb}, 0);
    idle();
    access(1, 0, 16'h03FF, 8'h00);
    check("R10 scratch not written", rdata, 8'h5A);
    idle();
  endtask

  task automatic t_base_2f8();
    base_sw = 8'hA0;
    access(0, 1, 16'h02FC, 8'h08);
    check("R1 2F8 window sel", sel, 1);
    access(1, 0, 16'h03FC, 8'h00);
    check("R1 old window misses", sel, 0);
    access(1, 0, 16'h02FC, 8'h00);
    check("R1 2F8 modemctl readback", rdata, 8'h08);
    idle();
    check("R8 modemctl stored", mctl, 8'h08);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        t_scratch_3f8();
        t_miss();
        t_disable();
        t_off01();
        t_off2();
        t_divisor();
        t_upper_offsets();
        t_collision();
        t_base_2f8();
      end
      begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule